// File: doc/BRIEF.md
# Byte-Lane Data Memory with Access-Size Control

This block is the data store of a simple load/store datapath. It holds a parameterised number of 32-bit words and is addressed by byte. A 2-bit access code, qualified by an enable, chooses between a full-word read and a write of one byte, one halfword or one word. The data port is 32 bits wide, and a partial write touches only the byte lanes that the low address bits select. Byte order within a word is little-endian.

Each access size has its own alignment rule. A read and a word write need `addr[1:0] == 0`. A halfword write needs `addr[0] == 0`. A byte write may go to any address. An access that breaks its rule raises `misalign` in the same cycle, and the write is dropped. Writes happen on the rising clock edge. Read data is combinational from the word the address selects. Address bits above the word index are ignored. The loaded value is not sign- or zero-extended here: the datapath does that.

Top module: `sized_data_mem`

## Requirements
- R1: While reset is held, and after reset is released, every word reads as zero and `misalign` is low.
- R2: With `en`=1, `ctl`=00 and `addr[1:0]`=00, `rdata` shows the word at index `addr[IDX_W+1:2]` in the same cycle and storage does not change. In every other cycle `rdata` is zero.
- R3: With `en`=1 and `ctl`=01, at a rising edge `wdata[7:0]` is written into byte lane `addr[1:0]`, where lane n is bits 8n+7:8n. The other three lanes are unchanged, and no byte address is misaligned.
- R4: With `en`=1, `ctl`=10 and `addr[0]`=0, at a rising edge `wdata[15:0]` is written into bits 31:16 if `addr[1]`=1, or into bits 15:0 if `addr[1]`=0. The other half is unchanged.
- R5: With `en`=1, `ctl`=11 and `addr[1:0]`=00, at a rising edge all 32 bits of `wdata` replace the word.
- R6: `misalign` is high, combinationally, exactly when `en`=1 and either `ctl` is 00 or 11 with `addr[1:0]`≠00, or `ctl` is 10 with `addr[0]`=1. A misaligned access writes nothing and reads zero.
- R7: With `en`=0, no word changes, `misalign` is low and `rdata` is zero, whatever `ctl`, `addr` and `wdata` are.
- R8: Address bits 31 down to `IDX_W+2` have no effect. Any two addresses that agree in bits `IDX_W+1:0` reach the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Access enable |
| ctl | input | 2 | Access code: 00 word read, 01 byte write, 10 halfword write, 11 word write |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data, taken from the low bits for partial writes |
| rdata | output | 32 | Read data, valid for an enabled aligned read and zero otherwise |
| misalign | output | 1 | High while the current enabled access breaks its alignment rule |

## Verification
The bench runs a small eight-word configuration. It drives every access code at every byte offset of that space, once enabled and once disabled, and each address carries different upper bits. Word writes at every offset come first. Aligned ones fill the store, and misaligned ones show whether the error path really drops the write. Byte writes at all four lanes and halfword writes at both halves then overwrite parts of known words. The read-back after each one tells a correct lane choice apart from a shifted, widened or dropped write. Disabled cycles and reads through a different upper-address alias separate real gating and index decoding from writes that merely happen to leave the same value.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    ACC_RD_WORD = 2'b00,
    ACC_WR_BYTE = 2'b01,
    ACC_WR_HALF = 2'b10,
    ACC_WR_WORD = 2'b11
  } acc_e;

  // Alignment rule per access size, from the two low address bits.
  function automatic logic acc_aligned(input acc_e code, input logic [1:0] lo);
    unique case (code)
      ACC_WR_BYTE: acc_aligned = 1'b1;
      ACC_WR_HALF: acc_aligned = ~lo[0];
      default:     acc_aligned = (lo == 2'b00);
    endcase
  endfunction

endpackage

// File: rtl/dmem_lane_decode.sv
module dmem_lane_decode
  import dmem_pkg::*;
(
  input  logic                en,
  input  logic [1:0]          ctl,
  input  logic [1:0]          lo,
  input  logic [WORD_W-1:0]   wdata,
  output logic                misalign,
  output logic                rd_ok,
  output logic                wr_ok,
  output logic [LANES-1:0]    lane_we,
  output logic [WORD_W-1:0]   lane_data
);

  acc_e code;
  logic ok;

  assign code = acc_e'(ctl);
  assign ok   = acc_aligned(code, lo);

  assign misalign = en & ~ok;
  assign rd_ok    = en & ok & (code == ACC_RD_WORD);
  assign wr_ok    = en & ok & (code != ACC_RD_WORD);

  always_comb begin
    lane_we   = '0;
    lane_data = wdata;
    unique case (code)
      ACC_WR_BYTE: begin
        lane_we[lo] = 1'b1;
        lane_data   = {LANES{wdata[LANE_W-1:0]}};
      end
      ACC_WR_HALF: begin
        lane_we   = lo[1] ? 4'b1100 : 4'b0011;
        lane_data = {2{wdata[2*LANE_W-1:0]}};
      end
      ACC_WR_WORD: begin
        lane_we   = '1;
        lane_data = wdata;
      end
      default: begin
        lane_we   = '0;
        lane_data = wdata;
      end
    endcase
  end

endmodule

// File: rtl/dmem_store.sv
module dmem_store
  import dmem_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  parameter int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [LANES-1:0]   lane_we,
  input  logic [WORD_W-1:0]  lane_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [WORD_W-1:0]  rd_word
);

  logic [WORD_W-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              sel;
    logic [WORD_W-1:0] nxt;

    assign sel = wr_en && (wr_idx == IDX_W'(w));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_comb begin
        if (lane_we[l]) nxt[l*LANE_W +: LANE_W] = lane_data[l*LANE_W +: LANE_W];
        else            nxt[l*LANE_W +: LANE_W] = mem_q[w][l*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[w] <= '0;
      else if (sel) mem_q[w] <= nxt;
    end
  end

  assign rd_word = mem_q[rd_idx];

endmodule

// File: rtl/sized_data_mem.sv
module sized_data_mem
  import dmem_pkg::*;
#(
  parameter int unsigned WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  ctl,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        misalign
);

  localparam int unsigned IDX_W = $clog2(WORDS);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic [IDX_W-1:0]  idx;
  logic              rd_ok;
  logic              wr_ok;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] lane_data;
  logic [WORD_W-1:0] rd_word;
  logic              unused_hi;

  assign idx       = addr[IDX_W+1:2];
  assign unused_hi = ^addr[31:IDX_W+2];

  dmem_lane_decode u_dec (
    .en        (en),
    .ctl       (ctl),
    .lo        (addr[1:0]),
    .wdata     (wdata),
    .misalign  (misalign),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok),
    .lane_we   (lane_we),
    .lane_data (lane_data)
  );

  dmem_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en     (wr_ok),
    .wr_idx    (idx),
    .lane_we   (lane_we),
    .lane_data (lane_data),
    .rd_idx    (idx),
    .rd_word   (rd_word)
  );

  assign rdata = rd_ok ? rd_word : '0;

endmodule

// File: rtl/sized_data_mem_chk.sv
module sized_data_mem_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        en,
  input logic [1:0]  ctl,
  input logic [31:0] addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        misalign
);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |-> (!misalign && rdata == 32'h0));

  assert_err_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    misalign |-> rdata == 32'h0);

  assert_byte_never_err_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && ctl == 2'b01) |-> !misalign);

  assert_half_rule_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && ctl == 2'b10) |-> (misalign == addr[0]));

  assert_write_zero_rdata_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && ctl != 2'b00) |-> rdata == 32'h0);

  assert_word_then_read_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && ctl == 2'b00 && addr == $past(addr) &&
     $past(en && ctl == 2'b11 && addr[1:0] == 2'b00)) |-> rdata == $past(wdata));

endmodule

bind sized_data_mem sized_data_mem_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_q_n),
  .en         (en),
  .ctl        (ctl),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .misalign   (misalign)
);

// File: tb/sized_data_mem_bench.sv
`timescale 1ns/1ps
module sized_data_mem_bench;

  localparam int WORDS = 8;
  localparam int SPAN  = WORDS * 4;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [1:0]  ctl;
  logic [31:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        misalign;

  int total;
  int bad;
  bit done;

  logic [31:0] model [WORDS];

  sized_data_mem #(.WORDS(WORDS)) u_sized_data_mem (
    .clk(clk), .rst_n(rst_n), .en(en), .ctl(ctl), .addr(addr),
    .wdata(wdata), .rdata(rdata), .misalign(misalign)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hi_bits(input int k);
    return (32'(k) * 32'h2D5F_3A40) & 32'hFFFF_FFE0;
  endfunction

  // Aligned read through an alias address; compares with the model.
  task automatic read_word(input int w, input int k, input string tag);
    @(negedge clk);
    en = 1'b1; ctl = 2'b00; addr = hi_bits(k) | 32'(w * 4); wdata = 32'hDEAD_0000 ^ 32'(k);
    #1;
    check(rdata == model[w], tag, rdata, model[w]);
    check(misalign == 1'b0, tag, 32'(misalign), 32'h0);
    @(posedge clk); #1;
    en = 1'b0;
  endtask

  task automatic do_op(input logic e, input logic [1:0] c, input int ba, input int k);
    logic        exp_err;
    logic [31:0] exp_rd;
    logic [31:0] d;
    int          w;
    int          lo;
    string       tag;
    w  = ba / 4;
    lo = ba % 4;
    d  = 32'hA5C3_0000 ^ (32'(ba) * 32'h0101_0107) ^ (32'(k) << 11);
    exp_err = e && (((c == 2'b00 || c == 2'b11) && lo != 0) || (c == 2'b10 && lo[0]));
    exp_rd  = (e && c == 2'b00 && lo == 0) ? model[w] : 32'h0;
    if (!e)          tag = "R7";
    else if (exp_err) tag = "R6";
    else case (c)
      2'b00: tag = "R2";
      2'b01: tag = "R3";
      2'b10: tag = "R4";
      default: tag = "R5";
    endcase
    @(negedge clk);
    en = e; ctl = c; addr = hi_bits(k) | 32'(ba); wdata = d;
    #1;
    check(misalign == exp_err, tag, 32'(misalign), 32'(exp_err));
    check(rdata == exp_rd, tag, rdata, exp_rd);
    @(posedge clk); #1;
    en = 1'b0;
    if (e && !exp_err) begin
      case (c)
        2'b01: model[w][8*lo +: 8] = d[7:0];
        2'b10: model[w][16*(lo/2) +: 16] = d[15:0];
        2'b11: model[w] = d;
        default: ;
      endcase
    end
    // Read back the touched word through another alias (R8).
    read_word(w, k + 977, (c == 2'b00) ? "R8" : tag);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    en = 1'b0; ctl = 2'b00; addr = '0; wdata = '0;
    for (int w = 0; w < WORDS; w++) model[w] = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(misalign == 1'b0, "R1", 32'(misalign), 32'h0);
    check(rdata == 32'h0, "R1", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int w = 0; w < WORDS; w++) read_word(w, w + 5, "R1");

    begin
      int k;
      logic [1:0] order [4];
      k = 1;
      order[0] = 2'b11; order[1] = 2'b01; order[2] = 2'b10; order[3] = 2'b00;
      for (int o = 0; o < 4; o++) begin
        for (int ba = 0; ba < SPAN; ba++) begin
          for (int e = 1; e >= 0; e--) begin
            do_op(e[0], order[o], ba, k);
            k++;
          end
        end
      end
    end

    for (int w = 0; w < WORDS; w++) read_word(w, w + 4001, "R8");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule